// File: doc/BRIEF.md
# Absolute Angle Serial Read Port

This block lets a host read a 12-bit absolute shaft angle over three wires: an active-low select, a host-driven serial clock and one data line that is driven only while the port is selected. A position word comes in from the angle counter. When select falls, the block captures that word into a shift register. It then moves the word out most significant bit first, one bit for each falling edge of the serial clock.

Select and the serial clock come from the host and are asynchronous to the block. Both pass through two-flop synchronizers into a system clock that runs at least eight times faster than the serial clock. All edge detection and timing checks run in that clock domain.

The host may stop after any number of bits. Back-to-back reads are allowed, and the block checks three intervals. The serial clock must wait after select falls. Select must hold after the last bit. Select must stay high for a gap before it falls again. A breach of any interval raises a sticky timing-error flag. Unused data lines of other ports on the same wire stay released.

Top module: `abs_angle_rdport`

## Requirements
- R1: While select (`sel_n`) is high, the output enable `sdo_oe` is 0 and `sdo` is high impedance. Both take effect on the third rising system clock edge after select rises.
- R2: A select fall that is not early (see R7) loads the current `pos_in` into the shift register. A change of `pos_in` after that has no effect on the bits of that read.
- R3: The loaded word leaves on `sdo` most significant bit first. The MSB is present once the load takes effect, and each accepted falling serial-clock edge advances one bit. The new bit is valid on the third rising system clock edge after the serial-clock fall.
- R4: After twelve accepted falling edges, `sdo` reads 0. Further falling edges, for as long as select stays low, keep returning 0.
- R5: Raising select after fewer than twelve bits ends the read. The next clean select fall loads a fresh word, and that word starts again from its MSB.
- R6: A serial-clock fall that comes less than SETUP_NS (600 ns, 30 cycles at 50 MHz) after the select fall, as seen after synchronization, shifts nothing and sets `timing_err`.
- R7: A select fall less than REARM_NS (250 ns, 13 cycles) after the previous select rise does not load `pos_in`, so the shift register keeps its old contents. It also sets `timing_err`.
- R8: A select rise less than HOLD_NS (100 ns, 5 cycles) after the last accepted serial-clock fall of a read that shifted at least one bit sets `timing_err`.
- R9: `timing_err` is 0 after reset. Once set, it stays set until the next clean select fall (one that loads, per R2), which clears it. If a violation occurs in the same cycle as the clean fall, the flag is set, not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_in | input | 12 | Absolute angle from the angle counter |
| sel_n | input | 1 | Host select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, idles high, asynchronous |
| sdo | output | 1 | Serial data, high impedance when not selected |
| sdo_oe | output | 1 | Output enable of the data driver |
| timing_err | output | 1 | Sticky flag for a breach of an access interval |

## Verification
Every host-side edge passes two synchronizer flops and one edge-detect register. So each result is due on the third rising system clock edge after its stimulus: loading and enabling the output after select falls, releasing the output after select rises, each new bit after a serial-clock fall, and every change of `timing_err`. The bench drives inputs on falling system clock edges. It samples three falling edges later, which is half a cycle after the result settles and before any later stimulus lands. The interval tests place their edges several cycles inside or outside the 30, 5 and 13 cycle windows. A one-cycle synchronizer skew therefore cannot flip an expected outcome.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

  // Ceiling conversion of a time interval in ns to system clock cycles.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned clk_mhz);
    return (ns * clk_mhz + 999) / 1000;
  endfunction

  // Width of a counter that must hold values 0..max_val.
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/rdp_sync_edge.sv
module rdp_sync_edge #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic fall,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= IDLE;
      s2_q <= IDLE;
      s3_q <= IDLE;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign fall = s3_q & ~s2_q;
  assign rise = ~s3_q & s2_q;
endmodule

// File: rtl/rdp_gap_timer.sv
module rdp_gap_timer #(
  parameter int unsigned LIMIT    = 30,
  parameter bit          RST_DONE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic done
);
  localparam int unsigned CW = rdp_pkg::cnt_width(LIMIT);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= RST_DONE ? LIM : '0;
    else if (clr)        cnt_q <= '0;
    else if (cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q >= LIM);
endmodule

// File: rtl/rdp_shifter.sv
module rdp_shifter #(
  parameter int unsigned W  = 12,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  q,
  output logic [CW-1:0] bits,
  output logic          msb
);
  localparam logic [CW-1:0] FULL = CW'(W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      bits <= '0;
    end else if (load) begin
      q    <= din;
      bits <= '0;
    end else if (shift) begin
      q <= {q[W-2:0], 1'b0};
      if (bits < FULL) bits <= bits + 1'b1;
    end
  end

  assign msb = q[W-1];
endmodule

// File: rtl/abs_angle_rdport.sv
module abs_angle_rdport #(
  parameter int unsigned W        = 12,
  parameter int unsigned CLK_MHZ  = 50,
  parameter int unsigned SETUP_NS = 600,
  parameter int unsigned HOLD_NS  = 100,
  parameter int unsigned REARM_NS = 250
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pos_in,
  input  logic         sel_n,
  input  logic         sclk,
  output logic         sdo,
  output logic         sdo_oe,
  output logic         timing_err
);
  localparam int unsigned SETUP_CYC = rdp_pkg::ns_to_cycles(SETUP_NS, CLK_MHZ);
  localparam int unsigned HOLD_CYC  = rdp_pkg::ns_to_cycles(HOLD_NS, CLK_MHZ);
  localparam int unsigned REARM_CYC = rdp_pkg::ns_to_cycles(REARM_NS, CLK_MHZ);
  localparam int unsigned CW        = rdp_pkg::cnt_width(W);

  // Synchronized levels and edge events.
  logic sel_lvl, sel_fall, sel_rise;
  logic sck_lvl, sck_fall, sck_rise;

  rdp_sync_edge #(.IDLE(1'b1)) u_sel_sync (
    .clk(clk), .rst_n(rst_n), .din(sel_n),
    .lvl(sel_lvl), .fall(sel_fall), .rise(sel_rise));

  rdp_sync_edge #(.IDLE(1'b1)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .din(sclk),
    .lvl(sck_lvl), .fall(sck_fall), .rise(sck_rise));

  // Named internal events.
  logic active, setup_ok, hold_ok, rearm_ok;
  logic load, shift_ok, sclk_early, gap_short, release_short;
  logic [W-1:0]  shreg;
  logic [CW-1:0] bit_cnt;
  logic          msb;
  logic          oe_q, err_q;

  assign active = ~sel_lvl;

  // Setup window: held at zero while not selected.
  rdp_gap_timer #(.LIMIT(SETUP_CYC), .RST_DONE(1'b0)) u_setup (
    .clk(clk), .rst_n(rst_n), .clr(sel_lvl), .done(setup_ok));

  // Hold window: restarted on each accepted bit.
  rdp_gap_timer #(.LIMIT(HOLD_CYC), .RST_DONE(1'b1)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(shift_ok), .done(hold_ok));

  // Re-arm window: restarted when select rises.
  rdp_gap_timer #(.LIMIT(REARM_CYC), .RST_DONE(1'b1)) u_rearm (
    .clk(clk), .rst_n(rst_n), .clr(sel_rise), .done(rearm_ok));

  assign load          = sel_fall & rearm_ok;
  assign gap_short     = sel_fall & ~rearm_ok;
  assign shift_ok      = sck_fall & active & setup_ok;
  assign sclk_early    = sck_fall & active & ~setup_ok;
  assign release_short = sel_rise & (bit_cnt != '0) & ~hold_ok;

  rdp_shifter #(.W(W), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift_ok),
    .din(pos_in), .q(shreg), .bits(bit_cnt), .msb(msb));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      oe_q <= active;
      if (sclk_early | gap_short | release_short) err_q <= 1'b1;
      else if (load)                              err_q <= 1'b0;
    end
  end

  assign sdo_oe     = oe_q;
  assign sdo        = oe_q ? msb : 1'bz;
  assign timing_err = err_q;

  logic unused_ok;
  assign unused_ok = sck_lvl ^ sck_rise;
endmodule

// File: rtl/abs_angle_rdport_chk.sv
module abs_angle_rdport_chk #(
  parameter int unsigned W  = 12,
  parameter int unsigned CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  pos_in,
  input logic          sel_rise,
  input logic          load,
  input logic          shift_ok,
  input logic          sclk_early,
  input logic          gap_short,
  input logic          release_short,
  input logic [W-1:0]  shreg,
  input logic [CW-1:0] bit_cnt,
  input logic          sdo_oe,
  input logic          timing_err
);
  localparam logic [CW-1:0] FULL = CW'(W);

  p_release_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |=> !sdo_oe);

  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> shreg == $past(pos_in));

  p_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ok && !load && bit_cnt < FULL) |=> bit_cnt == CW'($past(bit_cnt) + 1'b1));

  p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == FULL) |-> (shreg == '0));

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);

  p_early_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_early && !load) |=> ($stable(shreg) && timing_err));

  p_short_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gap_short |=> ($stable(shreg) && timing_err));

  p_release_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    release_short |=> timing_err);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sclk_early) |=> !timing_err);
endmodule

bind abs_angle_rdport abs_angle_rdport_chk #(.W(W), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .sel_rise(sel_rise),
  .load(load), .shift_ok(shift_ok), .sclk_early(sclk_early),
  .gap_short(gap_short), .release_short(release_short), .shreg(shreg),
  .bit_cnt(bit_cnt), .sdo_oe(sdo_oe), .timing_err(timing_err));

// File: tb/abs_angle_rdport_tb_top.sv
module abs_angle_rdport_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pos_in = '0;
  logic        sel_n = 1'b1;
  logic        sclk = 1'b1;
  wire         sdo;
  logic        sdo_oe, timing_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  abs_angle_rdport dut_i (
    .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .sel_n(sel_n), .sclk(sclk),
    .sdo(sdo), .sdo_oe(sdo_oe), .timing_err(timing_err));

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One serial-clock fall, sampled three system edges later, then high again.
  task automatic clk_bit();
    sclk = 1'b0; wait_n(3);
  endtask
  task automatic clk_up();
    sclk = 1'b1; wait_n(7);
  endtask

  task automatic select(); sel_n = 1'b0; wait_n(3); endtask
  task automatic deselect(); sel_n = 1'b1; wait_n(3); endtask

  task automatic t_reset();
    check("R1 reset oe", sdo_oe, 1'b0);
    check("R9 reset err", timing_err, 1'b0);
  endtask

  task automatic t_full_read(input logic [11:0] w);
    pos_in = w;
    select();
    check("R1 oe on select", sdo_oe, 1'b1);
    check("R9 clean fall err", timing_err, 1'b0);
    pos_in = ~w;                          // R2: must not matter
    wait_n(40);
    check("R2/R3 MSB", sdo, w[11]);
    for (int i = 10; i >= 0; i--) begin
      clk_bit();
      check("R3 bit", sdo, w[i]);
      clk_up();
    end
    for (int k = 0; k < 3; k++) begin
      clk_bit();
      check("R4 zero fill", sdo, 1'b0);
      clk_up();
    end
    wait_n(20);
    deselect();
    check("R1 oe released", sdo_oe, 1'b0);
    check("R8 clean release", timing_err, 1'b0);
    wait_n(30);
  endtask

  task automatic t_partial(input logic [11:0] a, input logic [11:0] b);
    pos_in = a; select(); wait_n(40);
    for (int i = 10; i >= 7; i--) begin
      clk_bit(); check("R5 partial bit", sdo, a[i]); clk_up();
    end
    wait_n(20); deselect(); wait_n(30);
    pos_in = b; select(); wait_n(40);
    check("R5 fresh MSB", sdo, b[11]);
    clk_bit(); check("R5 fresh bit", sdo, b[10]); clk_up();
    check("R5 err clean", timing_err, 1'b0);
    wait_n(20); deselect(); wait_n(30);
  endtask

  task automatic t_early(input logic [11:0] w);
    pos_in = w; select(); wait_n(7);       // about 10 cycles into window
    clk_bit();
    check("R6 early ignored", sdo, w[11]);
    check("R6 err set", timing_err, 1'b1);
    clk_up(); wait_n(30);
    clk_bit();
    check("R6 late accepted", sdo, w[10]);
    check("R9 err sticky", timing_err, 1'b1);
    clk_up(); wait_n(20); deselect(); wait_n(30);
    pos_in = 12'h000; select();
    check("R9 err cleared", timing_err, 1'b0);
    wait_n(20); deselect(); wait_n(30);
  endtask

  task automatic t_short_gap();
    t_full_read(12'hFFF);                  // register now all zero
    deselect(); wait_n(30);
    pos_in = 12'hFFF; select(); wait_n(40);
    for (int i = 0; i < 12; i++) begin clk_bit(); clk_up(); end
    wait_n(20);
    sel_n = 1'b1; wait_n(4);
    pos_in = 12'hFFF; sel_n = 1'b0; wait_n(3);
    check("R7 no reload", sdo, 1'b0);
    check("R7 err set", timing_err, 1'b1);
    wait_n(20); deselect(); wait_n(30);
    select(); check("R9 clean fall clears", timing_err, 1'b0);
    wait_n(20); deselect(); wait_n(30);
  endtask

  task automatic t_release_short();
    pos_in = 12'h5A5; select(); wait_n(40);
    clk_bit();
    check("R8 no err before", timing_err, 1'b0);
    sclk = 1'b1;
    deselect();
    check("R8 err set", timing_err, 1'b1);
    wait_n(30);
    select(); check("R9 cleared after R8", timing_err, 1'b0);
    wait_n(20); deselect(); wait_n(30);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    t_reset();
    t_full_read(12'hA5C);
    t_full_read(12'h801);
    t_partial(12'h3C7, 12'hC38);
    t_early(12'hB2D);
    t_short_gap();
    t_release_short();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule